// File: doc/BRIEF.md
# Video Sync Mode Timing Controller

This block produces the horizontal and vertical timing for the front end of a digital video encoder that takes YCrCb samples on a pixel clock supplied from outside. It has a single pair of line and frame counters. Three modes decide how those counters are kept in step.

- **Master mode:** the counters run freely, and the block drives the horizontal sync, vertical sync and field pins itself.
- **Embedded-code mode:** the block watches the 8-bit sample stream for timing reference codes. Each code is a preamble FF 00 00 followed by a flag byte. The block realigns the counters from those codes and still drives the sync pins.
- **Pulse-driven mode:** the sync pins are inputs. Their rising edges realign the counters. A configuration bit chooses where an incoming horizontal pulse lands in the line: at the start of blanking or at the start of active video.

The block reports the following:

- both counters;
- a field flag;
- an active-video flag;
- registered horizontal and vertical sync levels;
- output enables for the sync pins and the field pin;
- a flag that rises when a following mode sees no reference for longer than one line plus a margin.

Top module: `vid_sync_ctrl`

## Requirements
- R1: `sync_oe` is 1 in master mode and in embedded-code slave mode, and 0 in pulse-driven slave mode. `field_oe` is 1 only in master mode. Both are registered, so they follow the mode bits one clock later.
- R2: In master mode `h_cnt` counts 0 up to line length minus 1 and then wraps. The line length is `LINE_CCIR` when `rate_sel`=1 and `LINE_SQ` when `rate_sel`=0. `v_cnt` advances each time `h_cnt` returns to 0 from a nonzero value, and wraps to 0 after `FRAME_LINES`-1.
- R3: The flags below are valid in the same cycle as the counters they describe. Let r be `v_cnt`, minus `FIELD0_LINES` when `field` is 1. Let the blanking width be `HBLANK_CCIR` when `rate_sel`=1 and `HBLANK_SQ` when `rate_sel`=0.
  - `field` = (`v_cnt` >= `FIELD0_LINES`).
  - `hsync_out` = (`h_cnt` < `HSYNC_W`).
  - `vsync_out` = (r < `VSYNC_LINES`).
  - `active` = (`h_cnt` >= blanking width) and (r >= `VBLANK_LINES`).
- R4: In pulse-driven mode (`slave_sel`=1, `int_slave_sel`=0), a rising edge on `hsync_in` loads `h_cnt` on that clock. With `hreset_mode`=0 it loads 0, which counts as a new line and advances `v_cnt`. With `hreset_mode`=1 it loads the blanking width, and `v_cnt` does not advance.
- R5: In master mode, `hreset_mode`, `hsync_in` and `vsync_in` have no effect on the counters.
- R6: In pulse-driven mode, a rising edge on `vsync_in` loads `v_cnt` with 0 in two cases: when `hsync_in` rises on the same clock, or when the current `h_cnt` is below half the line length. Otherwise it loads `FIELD0_LINES`.
- R7: In embedded-code mode (`slave_sel`=1, `int_slave_sel`=1), a code is four consecutive bytes FF, 00, 00, XY. XY is laid out as bit7=1, bit6=F, bit5=V, bit4=H, bit3=V^H, bit2=F^H, bit1=F^V, bit0=F^V^H. On the clock that samples a valid XY:
  - `h_cnt` loads 3 when H=1.
  - `h_cnt` loads the blanking width minus 1 when H=0.
  - When H=1 and F differs from the F of the previous valid H=1 code, `v_cnt` loads `FIELD0_LINES` if F=1 or 0 if F=0. That previous F is 0 after reset.
- R8: An XY byte with bit7=0, or with protection bits that do not match, is ignored. The counters keep stepping as if no code had arrived.
- R9: In a slave mode, `lock_lost` rises on the clock that follows line length + `LOCK_MARGIN` clocks without a reference. A reference is an `hsync_in` rising edge in pulse-driven mode, or a valid code in embedded-code mode. `lock_lost` clears on the clock that takes the next reference, and it is always 0 in master mode.
- R10: While `rst` is high, the outputs hold these values:

  | Output | Value during reset |
  |---|---|
  | `h_cnt` | 0 |
  | `v_cnt` | 0 |
  | `field` | 0 |
  | `active` | 0 |
  | `hsync_out` | 1 |
  | `vsync_out` | 1 |
  | `lock_lost` | 0 |
  | `sync_oe` | 1 |
  | `field_oe` | 1 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_sel | input | 1 | 1 = slave operation, 0 = master |
| int_slave_sel | input | 1 | In slave operation: 1 = embedded codes, 0 = external pulses |
| rate_sel | input | 1 | 1 = 27 MHz line length, 0 = square-pixel line length |
| hreset_mode | input | 1 | Pulse-driven mode: 1 = pulse marks active start, 0 = blanking start |
| vid_data | input | 8 | Multiplexed YCrCb byte stream |
| hsync_in | input | 1 | Horizontal sync pulse from outside |
| vsync_in | input | 1 | Vertical sync pulse from outside |
| h_cnt | output | HW | Horizontal position in clocks |
| v_cnt | output | VW | Line number within the frame |
| field | output | 1 | Second-field flag |
| active | output | 1 | Active picture region |
| hsync_out | output | 1 | Generated horizontal sync level |
| vsync_out | output | 1 | Generated vertical sync level |
| sync_oe | output | 1 | Drive enable for the horizontal and vertical sync pins |
| field_oe | output | 1 | Drive enable for the field pin |
| lock_lost | output | 1 | No reference seen within one line plus margin |

## Verification
In pulse-driven mode, a horizontal reload and a vertical reload can land on the same clock. The field choice depends on the horizontal position, and that position is being overwritten on that clock. The bench lets the counter run past half the line and then raises both pulses together. It expects the line counter to go to 0, not to the second-field value, and the horizontal counter to take the selected reference point. A separate check raises the vertical pulse alone on each side of the half-line, so that both outcomes of the rule are seen.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  typedef enum logic [1:0] {
    MODE_MASTER = 2'd0,
    MODE_EXT    = 2'd1,
    MODE_INT    = 2'd2
  } vsc_mode_e;

  // protection nibble expected for a given F/V/H triple
  function automatic logic [3:0] vsc_prot(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vsc_code_det.sv
module vsc_code_det (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] data,
  output logic       hit,
  output logic       f_bit,
  output logic       v_bit,
  output logic       h_bit
);
  import vsc_pkg::*;

  logic [7:0] b_old, b_mid, b_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_old <= '0;
      b_mid <= '0;
      b_new <= '0;
    end else begin
      b_old <= b_mid;
      b_mid <= b_new;
      b_new <= data;
    end
  end

  logic preamble;
  assign preamble = (b_old == 8'hFF) && (b_mid == 8'h00) && (b_new == 8'h00);
  assign f_bit    = data[6];
  assign v_bit    = data[5];
  assign h_bit    = data[4];
  assign hit      = preamble && data[7] && (data[3:0] == vsc_prot(data[6], data[5], data[4]));

endmodule

// File: rtl/vsc_timing_core.sv
module vsc_timing_core #(
  parameter int FRAME_LINES  = 525,
  parameter int FIELD0_LINES = 263,
  parameter int VBLANK_LINES = 20,
  parameter int VSYNC_LINES  = 3,
  parameter int HSYNC_W      = 128,
  parameter int HW           = 11,
  parameter int VW           = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] line_len,
  input  logic [HW-1:0] hblank,
  input  logic          h_ld,
  input  logic [HW-1:0] h_ld_val,
  input  logic          v_ld,
  input  logic [VW-1:0] v_ld_val,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          field,
  output logic          active,
  output logic          hsync_o,
  output logic          vsync_o
);
  localparam logic [VW-1:0] LAST_V = VW'(FRAME_LINES - 1);
  localparam logic [VW-1:0] F0_V   = VW'(FIELD0_LINES);
  localparam logic [VW-1:0] VBL_V  = VW'(VBLANK_LINES);
  localparam logic [VW-1:0] VSW_V  = VW'(VSYNC_LINES);
  localparam logic [HW-1:0] HSW_H  = HW'(HSYNC_W);

  logic [HW-1:0] h_nxt;
  logic [VW-1:0] v_nxt, v_rel;
  logic          line_adv, f_nxt;

  always_comb begin
    if (h_ld)                           h_nxt = h_ld_val;
    else if (h_cnt >= line_len - HW'(1)) h_nxt = '0;
    else                                h_nxt = h_cnt + HW'(1);
    line_adv = (h_nxt == '0) && (h_cnt != '0);
    if (v_ld)          v_nxt = v_ld_val;
    else if (line_adv) v_nxt = (v_cnt >= LAST_V) ? '0 : v_cnt + VW'(1);
    else               v_nxt = v_cnt;
    f_nxt = (v_nxt >= F0_V);
    v_rel = f_nxt ? v_nxt - F0_V : v_nxt;
  end

  // flags decoded from next-state values so they line up with the counters
  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt   <= '0;
      v_cnt   <= '0;
      field   <= 1'b0;
      active  <= 1'b0;
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
    end else begin
      h_cnt   <= h_nxt;
      v_cnt   <= v_nxt;
      field   <= f_nxt;
      active  <= (h_nxt >= hblank) && (v_rel >= VBL_V);
      hsync_o <= (h_nxt < HSW_H);
      vsync_o <= (v_rel < VSW_V);
    end
  end

endmodule

// File: rtl/vsc_lock_mon.sv
module vsc_lock_mon #(
  parameter int HW          = 11,
  parameter int TW          = 11,
  parameter int LOCK_MARGIN = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          follow,
  input  logic          ref_p,
  input  logic [HW-1:0] line_len,
  output logic          lock_lost
);
  logic [TW-1:0] since_ref, limit;

  assign limit = TW'(line_len) + TW'(LOCK_MARGIN);

  always_ff @(posedge clk) begin
    if (rst || !follow || ref_p) begin
      since_ref <= '0;
      lock_lost <= 1'b0;
    end else begin
      if (since_ref != '1) since_ref <= since_ref + TW'(1);
      if (since_ref >= limit) lock_lost <= 1'b1;
    end
  end

endmodule

// File: rtl/vid_sync_ctrl.sv
module vid_sync_ctrl #(
  parameter int LINE_CCIR    = 1716,
  parameter int LINE_SQ      = 1560,
  parameter int HBLANK_CCIR  = 276,
  parameter int HBLANK_SQ    = 280,
  parameter int HSYNC_W      = 128,
  parameter int FRAME_LINES  = 525,
  parameter int FIELD0_LINES = 263,
  parameter int VBLANK_LINES = 20,
  parameter int VSYNC_LINES  = 3,
  parameter int LOCK_MARGIN  = 64,
  localparam int LMAX = (LINE_CCIR > LINE_SQ) ? LINE_CCIR : LINE_SQ,
  localparam int HW   = $clog2(LMAX),
  localparam int VW   = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_sel,
  input  logic          int_slave_sel,
  input  logic          rate_sel,
  input  logic          hreset_mode,
  input  logic [7:0]    vid_data,
  input  logic          hsync_in,
  input  logic          vsync_in,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          field,
  output logic          active,
  output logic          hsync_out,
  output logic          vsync_out,
  output logic          sync_oe,
  output logic          field_oe,
  output logic          lock_lost
);
  import vsc_pkg::*;

  localparam int TW = $clog2(LMAX + LOCK_MARGIN + 2);
  localparam logic [VW-1:0] F0_V = VW'(FIELD0_LINES);

  vsc_mode_e     mode;
  logic [HW-1:0] line_len, hblank, h_ld_val;
  logic [VW-1:0] v_ld_val;
  logic          h_ld, v_ld, ref_p;
  logic          hs_q, vs_q, hs_rise, vs_rise, f_q;
  logic          code_hit, code_f, code_v, code_h;

  assign mode     = !slave_sel ? MODE_MASTER : (int_slave_sel ? MODE_INT : MODE_EXT);
  assign line_len = rate_sel ? HW'(LINE_CCIR)   : HW'(LINE_SQ);
  assign hblank   = rate_sel ? HW'(HBLANK_CCIR) : HW'(HBLANK_SQ);
  assign hs_rise  = hsync_in && !hs_q;
  assign vs_rise  = vsync_in && !vs_q;

  vsc_code_det u_det (
    .clk(clk), .rst(rst), .data(vid_data),
    .hit(code_hit), .f_bit(code_f), .v_bit(code_v), .h_bit(code_h)
  );

  logic unused_v;
  assign unused_v = code_v;

  always_comb begin
    h_ld     = 1'b0;
    h_ld_val = '0;
    v_ld     = 1'b0;
    v_ld_val = '0;
    ref_p    = 1'b0;
    case (mode)
      MODE_EXT: begin
        ref_p    = hs_rise;
        h_ld     = hs_rise;
        h_ld_val = hreset_mode ? hblank : '0;
        v_ld     = vs_rise;
        v_ld_val = (hs_rise || (h_cnt < (line_len >> 1))) ? '0 : F0_V;
      end
      MODE_INT: begin
        ref_p    = code_hit;
        h_ld     = code_hit;
        h_ld_val = code_h ? HW'(3) : hblank - HW'(1);
        v_ld     = code_hit && code_h && (code_f != f_q);
        v_ld_val = code_f ? F0_V : '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q     <= 1'b0;
      vs_q     <= 1'b0;
      f_q      <= 1'b0;
      sync_oe  <= 1'b1;
      field_oe <= 1'b1;
    end else begin
      hs_q     <= hsync_in;
      vs_q     <= vsync_in;
      if (mode == MODE_INT && code_hit && code_h) f_q <= code_f;
      sync_oe  <= (mode != MODE_EXT);
      field_oe <= (mode == MODE_MASTER);
    end
  end

  vsc_timing_core #(
    .FRAME_LINES(FRAME_LINES), .FIELD0_LINES(FIELD0_LINES),
    .VBLANK_LINES(VBLANK_LINES), .VSYNC_LINES(VSYNC_LINES),
    .HSYNC_W(HSYNC_W), .HW(HW), .VW(VW)
  ) u_core (
    .clk(clk), .rst(rst), .line_len(line_len), .hblank(hblank),
    .h_ld(h_ld), .h_ld_val(h_ld_val), .v_ld(v_ld), .v_ld_val(v_ld_val),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .field(field), .active(active),
    .hsync_o(hsync_out), .vsync_o(vsync_out)
  );

  vsc_lock_mon #(.HW(HW), .TW(TW), .LOCK_MARGIN(LOCK_MARGIN)) u_lock (
    .clk(clk), .rst(rst), .follow(slave_sel), .ref_p(ref_p),
    .line_len(line_len), .lock_lost(lock_lost)
  );

endmodule

// File: rtl/vsc_sync_chk.sv
module vsc_sync_chk #(
  parameter int LINE_CCIR    = 1716,
  parameter int LINE_SQ      = 1560,
  parameter int HBLANK_CCIR  = 276,
  parameter int HBLANK_SQ    = 280,
  parameter int HSYNC_W      = 128,
  parameter int FIELD0_LINES = 263,
  parameter int HW           = 11,
  parameter int VW           = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          slave_sel,
  input logic          int_slave_sel,
  input logic          rate_sel,
  input logic          hreset_mode,
  input logic          hsync_in,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic          field,
  input logic          hsync_out,
  input logic          sync_oe,
  input logic          field_oe,
  input logic          lock_lost
);
  logic          hs_seen;
  logic [HW-1:0] cur_len, cur_hb;

  assign cur_len = rate_sel ? HW'(LINE_CCIR)   : HW'(LINE_SQ);
  assign cur_hb  = rate_sel ? HW'(HBLANK_CCIR) : HW'(HBLANK_SQ);

  always_ff @(posedge clk) begin
    if (rst) hs_seen <= 1'b0;
    else     hs_seen <= hsync_in;
  end

  // R1
  master_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !slave_sel |=> (sync_oe && field_oe));
  // R1
  ext_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (slave_sel && !int_slave_sel) |=> (!sync_oe && !field_oe));
  // R2
  master_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!slave_sel && (h_cnt < cur_len - HW'(1))) |=> (h_cnt == $past(h_cnt) + HW'(1)));
  // R3
  field_flag_chk: assert property (@(posedge clk) disable iff (rst)
    field == (v_cnt >= VW'(FIELD0_LINES)));
  // R3
  hsync_level_chk: assert property (@(posedge clk) disable iff (rst)
    hsync_out == (h_cnt < HW'(HSYNC_W)));
  // R4
  ext_blank_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (slave_sel && !int_slave_sel && !hreset_mode && hsync_in && !hs_seen) |=> (h_cnt == '0));
  // R4
  ext_active_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (slave_sel && !int_slave_sel && hreset_mode && hsync_in && !hs_seen) |=> (h_cnt == $past(cur_hb)));
  // R9
  master_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !slave_sel |=> !lock_lost);

endmodule

bind vid_sync_ctrl vsc_sync_chk #(
  .LINE_CCIR(LINE_CCIR), .LINE_SQ(LINE_SQ), .HBLANK_CCIR(HBLANK_CCIR),
  .HBLANK_SQ(HBLANK_SQ), .HSYNC_W(HSYNC_W), .FIELD0_LINES(FIELD0_LINES),
  .HW(HW), .VW(VW)
) u_chk (
  .clk(clk), .rst(rst), .slave_sel(slave_sel), .int_slave_sel(int_slave_sel),
  .rate_sel(rate_sel), .hreset_mode(hreset_mode), .hsync_in(hsync_in),
  .h_cnt(h_cnt), .v_cnt(v_cnt), .field(field), .hsync_out(hsync_out),
  .sync_oe(sync_oe), .field_oe(field_oe), .lock_lost(lock_lost)
);

// File: tb/vid_sync_ctrl_bench.sv
module vid_sync_ctrl_bench;
  localparam int LC = 40, LS = 32, HBC = 10, HBS = 8, HSW = 4;
  localparam int FR = 7, F0 = 4, VBL = 1, VSL = 1, LM = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slave_sel = 1'b0, int_slave_sel = 1'b0, rate_sel = 1'b1, hreset_mode = 1'b0;
  logic [7:0] vid_data = 8'h10;
  logic       hsync_in = 1'b0, vsync_in = 1'b0;
  logic [5:0] h_cnt;
  logic [2:0] v_cnt;
  logic       field, active, hsync_out, vsync_out, sync_oe, field_oe, lock_lost;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  vid_sync_ctrl #(
    .LINE_CCIR(LC), .LINE_SQ(LS), .HBLANK_CCIR(HBC), .HBLANK_SQ(HBS),
    .HSYNC_W(HSW), .FRAME_LINES(FR), .FIELD0_LINES(F0),
    .VBLANK_LINES(VBL), .VSYNC_LINES(VSL), .LOCK_MARGIN(LM)
  ) u_vid_sync_ctrl (
    .clk(clk), .rst(rst), .slave_sel(slave_sel), .int_slave_sel(int_slave_sel),
    .rate_sel(rate_sel), .hreset_mode(hreset_mode), .vid_data(vid_data),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .field(field), .active(active), .hsync_out(hsync_out), .vsync_out(vsync_out),
    .sync_oe(sync_oe), .field_oe(field_oe), .lock_lost(lock_lost)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_frame(input string req, input int h, input int v, input int rate);
    int hb, vr, f;
    hb = rate ? HBC : HBS;
    f  = (v >= F0) ? 1 : 0;
    vr = f ? v - F0 : v;
    chk(req, h_cnt, h);
    chk(req, v_cnt, v);
    chk(req, field, f);
    chk(req, active, (h >= hb && vr >= VBL) ? 1 : 0);
    chk(req, hsync_out, (h < HSW) ? 1 : 0);
    chk(req, vsync_out, (vr < VSL) ? 1 : 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ticks(3);
    rst = 1'b0;
  endtask

  task automatic pulse_hs();
    hsync_in = 1'b1; tick(); hsync_in = 1'b0;
  endtask

  task automatic pulse_vs();
    vsync_in = 1'b1; tick(); vsync_in = 1'b0;
  endtask

  task automatic pulse_both();
    hsync_in = 1'b1; vsync_in = 1'b1; tick(); hsync_in = 1'b0; vsync_in = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b);
    vid_data = b; tick(); vid_data = 8'h10;
  endtask

  function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic feed_code(input logic [7:0] last);
    feed(8'hFF); feed(8'h00); feed(8'h00); feed(last);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 reset state
    rst = 1'b1;
    ticks(3);
    chk("R10", h_cnt, 0); chk("R10", v_cnt, 0); chk("R10", field, 0);
    chk("R10", active, 0); chk("R10", hsync_out, 1); chk("R10", vsync_out, 1);
    chk("R10", lock_lost, 0); chk("R10", sync_oe, 1); chk("R10", field_oe, 1);

    // R2 / R3 master sweep at both rates
    for (int rate = 1; rate >= 0; rate--) begin
      rate_sel = rate[0];
      do_reset();
      for (int k = 1; k <= 2 * FR * (rate ? LC : LS); k++) begin
        int len;
        len = rate ? LC : LS;
        tick();
        chk_frame(rate ? "R2_R3_ccir" : "R2_R3_sq", k % len, (k / len) % FR, rate);
      end
      chk("R1", sync_oe, 1); chk("R1", field_oe, 1); chk("R9", lock_lost, 0);
    end

    // R5 master ignores external pulses and hreset_mode
    rate_sel = 1'b1; hreset_mode = 1'b1;
    do_reset();
    ticks(3);
    pulse_hs();
    chk("R5", h_cnt, 4); chk("R5", v_cnt, 0);
    pulse_vs();
    chk("R5", h_cnt, 5); chk("R5", v_cnt, 0);

    // external slave
    slave_sel = 1'b1; int_slave_sel = 1'b0; hreset_mode = 1'b0;
    do_reset();
    ticks(7);
    chk("R1", sync_oe, 0); chk("R1", field_oe, 0);
    pulse_hs();                       // R4 blanking reference, new line
    chk("R4", h_cnt, 0); chk("R4", v_cnt, 1);
    ticks(4);
    pulse_vs();                       // R6 first half
    chk("R6", v_cnt, 0); chk("R6", h_cnt, 5);
    ticks(20);
    pulse_vs();                       // R6 second half
    chk_frame("R6", 26, F0, 1);
    hreset_mode = 1'b1;
    pulse_hs();                       // R4 active reference
    chk("R4", h_cnt, HBC); chk("R4", v_cnt, F0);
    ticks(20);
    chk("R6", h_cnt, 30);
    pulse_both();                     // R6 concurrent reloads
    chk("R6", h_cnt, HBC); chk("R6", v_cnt, 0); chk("R6", field, 0);
    ticks(LC + LM);                   // R9 timeout window
    chk("R9", lock_lost, 0);
    tick();
    chk("R9", lock_lost, 1);
    pulse_hs();
    chk("R9", lock_lost, 0);

    // embedded-code slave
    int_slave_sel = 1'b1; hreset_mode = 1'b0;
    do_reset();
    tick();
    chk("R1", sync_oe, 1); chk("R1", field_oe, 0);
    ticks(9);
    feed_code(xy(1'b0, 1'b0, 1'b1));  // R7 EAV, first field
    chk("R7", h_cnt, 3); chk("R7", v_cnt, 0);
    ticks(2);
    feed_code(xy(1'b1, 1'b0, 1'b1));  // R7 EAV, field change
    chk("R7", h_cnt, 3); chk("R7", v_cnt, F0); chk("R7", field, 1);
    feed_code(xy(1'b1, 1'b0, 1'b0));  // R7 SAV
    chk("R7", h_cnt, HBC - 1); chk("R7", v_cnt, F0);
    feed_code(8'h9C);                 // R8 bad protection
    chk("R8", h_cnt, 13); chk("R8", v_cnt, F0);
    feed_code(8'h1D);                 // R8 bit7 clear
    chk("R8", h_cnt, 17); chk("R8", v_cnt, F0);
    feed_code(xy(1'b1, 1'b0, 1'b1));
    chk("R7", h_cnt, 3); chk("R7", v_cnt, F0);
    ticks(LC + LM);
    chk("R9", lock_lost, 0);
    tick();
    chk("R9", lock_lost, 1);
    feed_code(xy(1'b1, 1'b0, 1'b1));
    chk("R9", lock_lost, 0); chk("R7", h_cnt, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule